// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit privileged control registers of a processor core behind one read port and one write port, each addressed by a 6-bit index. Every index has its own write rule: some registers take the full word, some keep only selected bits, two clear on any write, one becomes 1 when written, read-only indices refuse writes and write-only indices refuse reads. Any index outside the map refuses both. A refused access raises the port's fault output combinationally, in the same cycle as the request, and a faulting read returns zero.

Two registers have a special read view. The cycle-counter register returns its stored upper bits joined with the low bits of a free-running cycle count. The staged page-table-entry register returns its packed fields merged with the address-space number held in the translation-buffer ASN register. Writes to three translation-buffer control indices issue a registered one-cycle command pulse to an external translation buffer: invalidate all, invalidate process entries, or insert. The insert command carries the written tag, the staged entry fields and the current ASN.

Reset is synchronous and active high. Reads are combinational from the registered state. A write lands on the next clock edge, and its command pulse appears in the cycle after the write.

Top module: `pcr_bank`

## Requirements
- R1: While reset is high at a clock edge, every register and the cycle count are cleared to zero. No command pulse is high in the cycle after that edge.
- R2: A write to index 9 (interrupt priority level) stores only bits [4:0]. Writes to index 10 (AST request) and index 11 (AST enable) store only bits [3:0].
- R3: Writes to index 12 (current mode) and index 13 (data-TB mode) store only bits [4:3]. A write to index 14 (software interrupt request) stores only mask 0x7FFF0. A write to index 15 (exception address) stores the word with bit 1 forced to zero. A write to index 21 (TB ASN) stores only bits [63:57].
- R4: Indices 0 to 7 (scratch), 8 (base), 18 (cycle-counter high) and 22 (data-TB tag) store and read back the full 64-bit word.
- R5: Any write to index 16 (exception summary) or index 17 (exception mask) leaves that register at zero, whatever the write data.
- R6: A write to a read-only index (24 to 28) raises the write fault in the same cycle and changes no register. A read of a read-only index returns zero without a fault.
- R7: A read of a write-only index (32 to 38) raises the read fault and returns zero. A write to one of these indices is accepted without a fault.
- R8: Any index not listed in R2 to R7 or R10 to R13 (for example 23, 29 to 31 or 39 to 63) raises the fault on both ports, and a faulting read returns zero.
- R9: A read of index 18 returns the stored bits [63:32] joined with bits [31:0] of a cycle count. The count is zero after reset and rises by one on every clock edge without reset.
- R10: A write of any data to index 19 (cycle-counter control) stores the value 1.
- R11: A write to index 20 (staged entry) keeps these fields: frame number at [58:32], read enables at [11:8], write enables at [15:12], fault-on-read at bit 1, fault-on-write at bit 2 and address-space match at bit 4. A read of index 20 returns those fields ORed with index 21's bits [63:57].
- R12: A write to index 37 (invalidate all) raises tb_flush_all, and a write to index 36 (invalidate process) raises tb_flush_proc. Each pulse is high for exactly the one cycle after the write. At most one command pulse is high in any cycle.
- R13: A write to index 22 raises tb_insert for the one cycle after the write. In that cycle ins_tag holds the written data, ins_pte holds the stored fields of index 20, and ins_asn holds bits [63:57] of index 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Write refused, same cycle as the request |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read data, zero when idle or faulting |
| rd_fault | output | 1 | Read refused, same cycle as the request |
| tb_flush_all | output | 1 | One-cycle invalidate-all command |
| tb_flush_proc | output | 1 | One-cycle invalidate-process command |
| tb_insert | output | 1 | One-cycle insert command |
| ins_tag | output | 64 | Tag for the insert command |
| ins_pte | output | 64 | Staged entry fields for the insert command |
| ins_asn | output | 7 | Address-space number for the insert command |

## Verification
Each write is sent with all-ones data or a mixed bit pattern, so every mask is seen keeping exactly its own bits. A read-back then separates the masked, full-width, clear-on-write and set-to-one rules. Reads and writes to read-only, write-only and unmapped indices show which port faults for each access class and that a refused write leaves state unchanged. The cycle-counter read is compared with a cycle count the bench keeps itself, which shows whether the low half is live while the high half holds. Each command write is checked in the cycle after it and again one cycle later, so a pulse that is missing, late, too long or carrying the wrong fields is caught.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int unsigned IDX_W  = 6;
    localparam int unsigned DW     = 64;
    localparam int unsigned ASN_W  = 7;
    localparam int unsigned ASN_LO = DW - ASN_W;
    localparam int unsigned NREG   = 23;
    localparam int unsigned SLOT_W = $clog2(NREG);

    // stored, readable indices
    localparam logic [IDX_W-1:0] IX_BASE     = 6'd8;
    localparam logic [IDX_W-1:0] IX_IPL      = 6'd9;
    localparam logic [IDX_W-1:0] IX_AST_REQ  = 6'd10;
    localparam logic [IDX_W-1:0] IX_AST_EN   = 6'd11;
    localparam logic [IDX_W-1:0] IX_CUR_MODE = 6'd12;
    localparam logic [IDX_W-1:0] IX_DTB_MODE = 6'd13;
    localparam logic [IDX_W-1:0] IX_SWI      = 6'd14;
    localparam logic [IDX_W-1:0] IX_EXC_ADDR = 6'd15;
    localparam logic [IDX_W-1:0] IX_EXC_SUM  = 6'd16;
    localparam logic [IDX_W-1:0] IX_EXC_MASK = 6'd17;
    localparam logic [IDX_W-1:0] IX_CC       = 6'd18;
    localparam logic [IDX_W-1:0] IX_CC_CTL   = 6'd19;
    localparam logic [IDX_W-1:0] IX_PTE      = 6'd20;
    localparam logic [IDX_W-1:0] IX_ASN      = 6'd21;
    localparam logic [IDX_W-1:0] IX_TAG      = 6'd22;
    localparam logic [IDX_W-1:0] IX_LIMIT    = 6'd23;

    // read-only indices
    localparam logic [IDX_W-1:0] IX_INT_ID   = 6'd24;
    localparam logic [IDX_W-1:0] IX_SER_RCV  = 6'd25;
    localparam logic [IDX_W-1:0] IX_MM_STAT  = 6'd26;
    localparam logic [IDX_W-1:0] IX_ITB_TMP  = 6'd27;
    localparam logic [IDX_W-1:0] IX_DTB_TMP  = 6'd28;

    // write-only indices
    localparam logic [IDX_W-1:0] IX_HWI_CLR  = 6'd32;
    localparam logic [IDX_W-1:0] IX_SER_XMIT = 6'd33;
    localparam logic [IDX_W-1:0] IX_DC_FLUSH = 6'd34;
    localparam logic [IDX_W-1:0] IX_IC_FLUSH = 6'd35;
    localparam logic [IDX_W-1:0] IX_INV_PROC = 6'd36;
    localparam logic [IDX_W-1:0] IX_INV_ALL  = 6'd37;
    localparam logic [IDX_W-1:0] IX_ALT_MODE = 6'd38;

    localparam logic [DW-1:0] M_IPL  = 64'h0000_0000_0000_001F;
    localparam logic [DW-1:0] M_AST  = 64'h0000_0000_0000_000F;
    localparam logic [DW-1:0] M_MODE = 64'h0000_0000_0000_0018;
    localparam logic [DW-1:0] M_SWI  = 64'h0000_0000_0007_FFF0;
    localparam logic [DW-1:0] M_ASN  = 64'hFE00_0000_0000_0000;
    localparam logic [DW-1:0] M_PTE  = 64'h07FF_FFFF_0000_FF16;
    localparam logic [DW-1:0] M_EXCA = 64'hFFFF_FFFF_FFFF_FFFD;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_FLUSH_ALL,
        CMD_FLUSH_PROC,
        CMD_INSERT
    } pcr_cmd_e;

    typedef struct packed {
        logic            legal;
        logic            store;
        logic [DW-1:0]   value;
        pcr_cmd_e        cmd;
    } wr_dec_t;

endpackage

// File: rtl/pcr_wr_decode.sv
module pcr_wr_decode
    import pcr_pkg::*;
(
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    output wr_dec_t          dec
);

    always_comb begin
        dec.legal = 1'b1;
        dec.store = 1'b1;
        dec.value = wr_data;
        dec.cmd   = CMD_NONE;
        if (wr_idx < IX_BASE) begin
            // scratch slots keep the whole word
            dec.value = wr_data;
        end else begin
            case (wr_idx)
                IX_BASE, IX_CC:             dec.value = wr_data;
                IX_TAG:                     dec.cmd   = CMD_INSERT;
                IX_IPL:                     dec.value = wr_data & M_IPL;
                IX_AST_REQ, IX_AST_EN:      dec.value = wr_data & M_AST;
                IX_CUR_MODE, IX_DTB_MODE:   dec.value = wr_data & M_MODE;
                IX_SWI:                     dec.value = wr_data & M_SWI;
                IX_EXC_ADDR:                dec.value = wr_data & M_EXCA;
                IX_EXC_SUM, IX_EXC_MASK:    dec.value = '0;
                IX_CC_CTL:                  dec.value = 64'd1;
                IX_PTE:                     dec.value = wr_data & M_PTE;
                IX_ASN:                     dec.value = wr_data & M_ASN;
                IX_INT_ID, IX_SER_RCV, IX_MM_STAT, IX_ITB_TMP, IX_DTB_TMP: begin
                    dec.legal = 1'b0;
                    dec.store = 1'b0;
                end
                IX_HWI_CLR, IX_SER_XMIT, IX_DC_FLUSH, IX_IC_FLUSH, IX_ALT_MODE:
                    dec.store = 1'b0;
                IX_INV_ALL: begin
                    dec.store = 1'b0;
                    dec.cmd   = CMD_FLUSH_ALL;
                end
                IX_INV_PROC: begin
                    dec.store = 1'b0;
                    dec.cmd   = CMD_FLUSH_PROC;
                end
                default: begin
                    dec.legal = 1'b0;
                    dec.store = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pcr_rd_mux.sv
module pcr_rd_mux
    import pcr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [NREG-1:0][DW-1:0]  regs,
    input  logic [CNT_W-1:0]         cnt,
    output logic [DW-1:0]            data,
    output logic                     legal
);

    logic [SLOT_W-1:0] slot;
    assign slot = rd_idx[SLOT_W-1:0];

    always_comb begin
        legal = 1'b1;
        data  = '0;
        if (rd_idx < IX_LIMIT) begin
            if (rd_idx == IX_CC) begin
                data = {regs[IX_CC[SLOT_W-1:0]][DW-1:CNT_W], cnt};
            end else if (rd_idx == IX_PTE) begin
                data = regs[IX_PTE[SLOT_W-1:0]] | (regs[IX_ASN[SLOT_W-1:0]] & M_ASN);
            end else begin
                data = regs[slot];
            end
        end else if (rd_idx >= IX_INT_ID && rd_idx <= IX_DTB_TMP) begin
            data = '0;
        end else begin
            legal = 1'b0;
        end
    end

endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
    import pcr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [5:0]       wr_idx,
    input  logic [63:0]      wr_data,
    output logic             wr_fault,
    input  logic             rd_en,
    input  logic [5:0]       rd_idx,
    output logic [63:0]      rd_data,
    output logic             rd_fault,
    output logic             tb_flush_all,
    output logic             tb_flush_proc,
    output logic             tb_insert,
    output logic [63:0]      ins_tag,
    output logic [63:0]      ins_pte,
    output logic [6:0]       ins_asn
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [CNT_W-1:0]        cnt;
        logic                    p_all;
        logic                    p_proc;
        logic                    p_ins;
        logic [DW-1:0]           tag;
        logic [DW-1:0]           pte;
        logic [ASN_W-1:0]        asn;
    } state_t;

    state_t  s_d, s_q;
    wr_dec_t dec;
    logic [DW-1:0] rd_val;
    logic          rd_ok;

    logic [NREG-1:0][DW-1:0] regs_q;
    logic [CNT_W-1:0]        cnt_q;
    assign regs_q = s_q.regs;
    assign cnt_q  = s_q.cnt;

    pcr_wr_decode u_wr_decode (
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .dec     (dec)
    );

    pcr_rd_mux #(.CNT_W(CNT_W)) u_rd_mux (
        .rd_idx (rd_idx),
        .regs   (s_q.regs),
        .cnt    (s_q.cnt),
        .data   (rd_val),
        .legal  (rd_ok)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cnt    = s_q.cnt + CNT_W'(1);
        s_d.p_all  = 1'b0;
        s_d.p_proc = 1'b0;
        s_d.p_ins  = 1'b0;
        if (wr_en && dec.legal) begin
            if (dec.store) begin
                s_d.regs[wr_idx[SLOT_W-1:0]] = dec.value;
            end
            case (dec.cmd)
                CMD_FLUSH_ALL:  s_d.p_all  = 1'b1;
                CMD_FLUSH_PROC: s_d.p_proc = 1'b1;
                CMD_INSERT: begin
                    s_d.p_ins = 1'b1;
                    s_d.tag   = wr_data;
                    s_d.pte   = s_q.regs[IX_PTE[SLOT_W-1:0]];
                    s_d.asn   = s_q.regs[IX_ASN[SLOT_W-1:0]][DW-1:ASN_LO];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_fault      = wr_en & ~dec.legal;
    assign rd_fault      = rd_en & ~rd_ok;
    assign rd_data       = (rd_en && rd_ok) ? rd_val : '0;
    assign tb_flush_all  = s_q.p_all;
    assign tb_flush_proc = s_q.p_proc;
    assign tb_insert     = s_q.p_ins;
    assign ins_tag       = s_q.tag;
    assign ins_pte       = s_q.pte;
    assign ins_asn       = s_q.asn;

endmodule

// File: rtl/pcr_bank_chk.sv
module pcr_bank_chk
    import pcr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic [DW-1:0]            wr_data,
    input logic                     wr_fault,
    input logic                     rd_data_nz,
    input logic                     rd_fault,
    input logic                     tb_flush_all,
    input logic                     tb_flush_proc,
    input logic                     tb_insert,
    input logic [DW-1:0]            ins_tag,
    input logic [NREG-1:0][DW-1:0]  regs,
    input logic [CNT_W-1:0]         cnt
);

    logic ro_wr;
    assign ro_wr = wr_en && (wr_idx >= IX_INT_ID) && (wr_idx <= IX_DTB_TMP);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs == '0 && cnt == '0 && !tb_insert && !tb_flush_all && !tb_flush_proc));

    // R2
    a_r2_ipl_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_IPL) |=> regs[IX_IPL[SLOT_W-1:0]][DW-1:5] == '0);

    // R5
    a_r5_sum_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IX_EXC_SUM) |=> regs[IX_EXC_SUM[SLOT_W-1:0]] == '0);

    // R6
    a_r6_ro_fault: assert property (@(posedge clk) disable iff (rst)
        ro_wr |-> wr_fault);

    a_r6_ro_keep: assert property (@(posedge clk) disable iff (rst)
        ro_wr |=> regs == $past(regs));

    // R8
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
        rd_fault |-> !rd_data_nz);

    // R9
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + CNT_W'(1));

    // R12
    a_r12_one_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tb_flush_all, tb_flush_proc, tb_insert}));

    a_r12_flush_src: assert property (@(posedge clk) disable iff (rst)
        tb_flush_all |-> $past(wr_en && wr_idx == IX_INV_ALL));

    // R13
    a_r13_insert_src: assert property (@(posedge clk) disable iff (rst)
        tb_insert |-> ($past(wr_en && wr_idx == IX_TAG) && ins_tag == $past(wr_data)));

endmodule

bind pcr_bank pcr_bank_chk #(.CNT_W(CNT_W)) u_pcr_bank_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .wr_fault      (wr_fault),
    .rd_data_nz    (|rd_data),
    .rd_fault      (rd_fault),
    .tb_flush_all  (tb_flush_all),
    .tb_flush_proc (tb_flush_proc),
    .tb_insert     (tb_insert),
    .ins_tag       (ins_tag),
    .regs          (regs_q),
    .cnt           (cnt_q)
);

// File: tb/test_pcr_bank.sv
module test_pcr_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic [63:0] wr_data;
    logic        wr_fault;
    logic        rd_en;
    logic [5:0]  rd_idx;
    logic [63:0] rd_data;
    logic        rd_fault;
    logic        tb_flush_all, tb_flush_proc, tb_insert;
    logic [63:0] ins_tag, ins_pte;
    logic [6:0]  ins_asn;

    always #2 clk = ~clk;

    pcr_bank i_pcr_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_fault(rd_fault),
        .tb_flush_all(tb_flush_all), .tb_flush_proc(tb_flush_proc), .tb_insert(tb_insert),
        .ins_tag(ins_tag), .ins_pte(ins_pte), .ins_asn(ins_asn)
    );

    typedef enum int {K_RDATA, K_RFAULT, K_WFAULT, K_PULSE, K_TAG, K_PTE, K_ASN} kind_e;
    typedef struct {
        int          cyc;
        kind_e       kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    item_t       keep[$];
    int          cyc = 0;
    logic [31:0] cnt_model = '0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    // cycle bookkeeping: the count clears while reset is high, else steps
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) cnt_model = '0;
        else     cnt_model = cnt_model + 32'd1;
    end

    task automatic push(input int c, input kind_e k, input logic [63:0] e, input string r);
        item_t it;
        it.cyc = c; it.kind = k; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    // monitor: compare every item due in this cycle, mid-cycle
    always @(negedge clk) begin
        logic [63:0] act;
        keep.delete();
        foreach (sb[i]) begin
            if (sb[i].cyc == cyc) begin
                case (sb[i].kind)
                    K_RDATA:  act = rd_data;
                    K_RFAULT: act = {63'd0, rd_fault};
                    K_WFAULT: act = {63'd0, wr_fault};
                    K_PULSE:  act = {61'd0, tb_insert, tb_flush_proc, tb_flush_all};
                    K_TAG:    act = ins_tag;
                    K_PTE:    act = ins_pte;
                    default:  act = {57'd0, ins_asn};
                endcase
                n_cmp++;
                if (act !== sb[i].exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                             sb[i].req, sb[i].kind, cyc, act, sb[i].exp);
                end
            end else if (sb[i].cyc < cyc) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s stale item actual=missed expected=cycle %0d", sb[i].req, sb[i].cyc);
            end else begin
                keep.push_back(sb[i]);
            end
        end
        sb = keep;
    end

    task automatic do_wr(input logic [5:0] idx, input logic [63:0] d,
                         input logic efault, input logic [2:0] pmask, input string r);
        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b1; wr_idx = idx; wr_data = d;
        push(cyc,     K_WFAULT, {63'd0, efault}, r);
        push(cyc + 1, K_PULSE,  {61'd0, pmask},  r);
    endtask

    task automatic do_rd(input logic [5:0] idx, input logic [63:0] edata,
                         input logic efault, input string r);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b1; rd_idx = idx;
        push(cyc, K_RDATA,  edata, r);
        push(cyc, K_RFAULT, {63'd0, efault}, r);
    endtask

    task automatic do_rd_cc(input logic [31:0] hi, input string r);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b1; rd_idx = 6'd18;
        push(cyc, K_RDATA,  {hi, cnt_model}, r);
        push(cyc, K_RFAULT, 64'd0, r);
    endtask

    task automatic do_idle();
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_idx = '0; rd_idx = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        push(cyc, K_PULSE, 64'd0, "R1 no pulse after reset");
        do_rd(6'd0,  64'd0, 1'b0, "R1 scratch cleared");
        do_rd(6'd9,  64'd0, 1'b0, "R1 ipl cleared");
        do_rd(6'd22, 64'd0, 1'b0, "R1 tag cleared");

        // R4: full-width registers
        do_wr(6'd3,  64'hDEAD_BEEF_0123_4567, 1'b0, 3'b000, "R4 scratch write");
        do_wr(6'd8,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R4 base write");
        do_rd(6'd3,  64'hDEAD_BEEF_0123_4567, 1'b0, "R4 scratch readback");
        do_rd(6'd8,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R4 base readback");

        // R2: narrow masks
        do_wr(6'd9,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R2 ipl write");
        do_wr(6'd10, 64'h0000_0000_0000_ABCD, 1'b0, 3'b000, "R2 ast req write");
        do_wr(6'd11, 64'hFFFF_FFFF_FFFF_FFF6, 1'b0, 3'b000, "R2 ast en write");
        do_rd(6'd9,  64'h1F, 1'b0, "R2 ipl keeps [4:0]");
        do_rd(6'd10, 64'hD,  1'b0, "R2 ast req keeps [3:0]");
        do_rd(6'd11, 64'h6,  1'b0, "R2 ast en keeps [3:0]");

        // R3: mode, software interrupt, exception address, ASN
        do_wr(6'd12, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R3 cur mode write");
        do_wr(6'd13, 64'h0000_0000_0000_000F, 1'b0, 3'b000, "R3 dtb mode write");
        do_wr(6'd14, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R3 swi write");
        do_wr(6'd15, 64'h0000_0000_0000_00FF, 1'b0, 3'b000, "R3 exc addr write");
        do_wr(6'd21, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R3 asn write");
        do_rd(6'd12, 64'h18, 1'b0, "R3 cur mode mask");
        do_rd(6'd13, 64'h08, 1'b0, "R3 dtb mode mask");
        do_rd(6'd14, 64'h7FFF0, 1'b0, "R3 swi mask");
        do_rd(6'd15, 64'hFD, 1'b0, "R3 exc addr bit1 zero");
        do_rd(6'd21, 64'hFE00_0000_0000_0000, 1'b0, "R3 asn mask");

        // R5: clear on write
        do_wr(6'd16, 64'h0000_0000_0000_FFFF, 1'b0, 3'b000, "R5 exc sum write");
        do_wr(6'd17, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R5 exc mask write");
        do_rd(6'd16, 64'd0, 1'b0, "R5 exc sum cleared");
        do_rd(6'd17, 64'd0, 1'b0, "R5 exc mask cleared");

        // R6: read-only indices
        do_wr(6'd24, 64'h55, 1'b1, 3'b000, "R6 int id write faults");
        do_wr(6'd26, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'b000, "R6 mm stat write faults");
        do_rd(6'd24, 64'd0, 1'b0, "R6 int id reads zero");
        do_rd(6'd28, 64'd0, 1'b0, "R6 dtb temp reads zero");
        do_rd(6'd3,  64'hDEAD_BEEF_0123_4567, 1'b0, "R6 state unchanged");

        // R7: write-only indices
        do_wr(6'd34, 64'h1234, 1'b0, 3'b000, "R7 dc flush write ok");
        do_wr(6'd38, 64'hFF,   1'b0, 3'b000, "R7 alt mode write ok");
        do_rd(6'd32, 64'd0, 1'b1, "R7 hwint clr read faults");
        do_rd(6'd37, 64'd0, 1'b1, "R7 inv all read faults");
        do_rd(6'd38, 64'd0, 1'b1, "R7 alt mode read faults");

        // R8: unmapped indices
        do_wr(6'd50, 64'hAAAA, 1'b1, 3'b000, "R8 unmapped write faults");
        do_wr(6'd23, 64'hAAAA, 1'b1, 3'b000, "R8 gap write faults");
        do_rd(6'd50, 64'd0, 1'b1, "R8 unmapped read faults");
        do_rd(6'd63, 64'd0, 1'b1, "R8 top index read faults");

        // R9: merged cycle counter
        do_wr(6'd18, 64'h1234_5678_9ABC_DEF0, 1'b0, 3'b000, "R9 cc write");
        do_rd_cc(32'h1234_5678, "R9 cc merged read");
        do_idle();
        do_idle();
        do_rd_cc(32'h1234_5678, "R9 cc merged read later");

        // R10: counter control
        do_wr(6'd19, 64'h0000_0000_0000_0FF0, 1'b0, 3'b000, "R10 cc ctl write");
        do_rd(6'd19, 64'd1, 1'b0, "R10 cc ctl is one");

        // R11: staged entry packing
        do_wr(6'd20, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'b000, "R11 pte write ones");
        do_rd(6'd20, 64'hFFFF_FFFF_0000_FF16, 1'b0, "R11 pte packed with asn");
        do_wr(6'd20, 64'h0000_0000_0000_1102, 1'b0, 3'b000, "R11 pte write mixed");
        do_rd(6'd20, 64'hFE00_0000_0000_1102, 1'b0, "R11 pte mixed read");

        // R12: flush pulses, each followed by a plain write so the next cycle is checked
        do_wr(6'd37, 64'hFFFF, 1'b0, 3'b001, "R12 invalidate all pulse");
        do_wr(6'd0,  64'd7,    1'b0, 3'b000, "R12 pulse one cycle");
        do_wr(6'd36, 64'hFFFF, 1'b0, 3'b010, "R12 invalidate process pulse");
        do_wr(6'd1,  64'd9,    1'b0, 3'b000, "R12 pulse one cycle proc");

        // R13: insert command with staged fields
        do_wr(6'd22, 64'h0000_0000_0000_CAFE, 1'b0, 3'b100, "R13 insert pulse");
        push(cyc + 1, K_TAG, 64'h0000_0000_0000_CAFE, "R13 insert tag");
        push(cyc + 1, K_PTE, 64'h0000_0000_0000_1102, "R13 insert pte");
        push(cyc + 1, K_ASN, 64'h7F, "R13 insert asn");
        do_wr(6'd2, 64'd1, 1'b0, 3'b000, "R13 pulse one cycle");
        do_rd(6'd22, 64'h0000_0000_0000_CAFE, 1'b0, "R4 tag readback");

        do_idle();
        do_idle();
        do_idle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule